// File: doc/BRIEF.md
# Polarity-configurable FIFO with occupancy thresholds

This block is a single-clock first-in first-out queue for words of a configurable width. A push stores the word on the data input; a pop moves the oldest stored word into a dedicated output register. That register is separate from the queue storage and keeps its value until the next pop that succeeds. At most one operation happens per clock edge. When both requests are active, the push wins, unless the queue is full. A full queue cannot take a push, so in that case the pop is carried out.

A single occupancy counter produces four status flags: full, empty, almost-full and almost-empty. The two almost thresholds are integer parameters. A threshold outside the range 1..DEPTH makes the matching almost flag behave exactly like full or empty. Each of the two request inputs and each of the four flag outputs has its own polarity parameter, so the block can be placed between neighbours with mixed signalling conventions without glue logic.

Top module: `polfifo`

## Requirements
- R1: A synchronous active-high reset empties the queue and clears the data output to zero. While reset is applied and right after it, empty and almost-empty are active, and full and almost-full are inactive.
- R2: Words leave the queue in the order they entered. The rdata_o register takes the new word on the clock edge of the pop, and the storage wraps around correctly when more than DEPTH words have passed through it.
- R3: rdata_o holds its value through every cycle without a successful pop: idle cycles, pushes, blocked pops and reset release.
- R4: When push and pop are both active and the queue is not full, only the push is carried out. The occupancy rises by one and rdata_o is unchanged. This applies with an empty queue and with a partly filled one.
- R5: When push and pop are both active and the queue is full, only the pop is carried out. The occupancy falls by one and the pushed word is dropped.
- R6: A push on a full queue is ignored. The occupancy stays at DEPTH and no stored word is overwritten, which later pops show.
- R7: A pop on an empty queue is ignored. rdata_o keeps its value and the occupancy stays at zero.
- R8: Full is active exactly when the occupancy equals DEPTH. Empty is active exactly when the occupancy is zero.
- R9: Almost-full is active when the occupancy is at or above AFULL_LEVEL. If AFULL_LEVEL is at most 0 or larger than DEPTH, almost-full equals full.
- R10: Almost-empty is active when the occupancy is at or below AEMPTY_LEVEL. If AEMPTY_LEVEL is at most 0 or larger than DEPTH, almost-empty equals empty.
- R11: Each polarity parameter (PUSH_ACT_LOW, POP_ACT_LOW, FULL_ACT_LOW, EMPTY_ACT_LOW, AFULL_ACT_LOW, AEMPTY_ACT_LOW) works independently. A value of 0 means the port is asserted at logic 1. A value of 1 means the port is asserted at logic 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push request, polarity set by PUSH_ACT_LOW |
| pop_i | input | 1 | Pop request, polarity set by POP_ACT_LOW |
| wdata_i | input | WIDTH | Word stored by a push |
| rdata_o | output | WIDTH | Registered word delivered by the last successful pop |
| full_o | output | 1 | Occupancy equals DEPTH, polarity set by FULL_ACT_LOW |
| empty_o | output | 1 | Occupancy is zero, polarity set by EMPTY_ACT_LOW |
| almost_full_o | output | 1 | Occupancy at or above the resolved upper threshold |
| almost_empty_o | output | 1 | Occupancy at or below the resolved lower threshold |

## Verification
A wrong occupancy count appears on the flag outputs in the same cycle it is registered. This is because all four flags are decoded combinationally from the counter, and three instances with different thresholds and polarities watch it from different decode points. A wrong pointer or a lost precedence decision appears on rdata_o at the first pop that should return the disturbed word. That can be several cycles later, so every vector compares rdata_o and all flags against a reference queue model. A wrong choice between push and pop with both requests active changes the count by two steps relative to the model, which the flags expose at the very next edge.

// File: rtl/polfifo_pkg.sv
package polfifo_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } fifo_op_e;

    typedef struct packed {
        logic full;
        logic empty;
        logic afull;
        logic aempty;
    } fifo_flags_t;

    // A threshold inside 1..depth is used as is; anything else takes the fallback.
    function automatic int resolve_level(input int level, input int depth, input int fallback);
        return ((level >= 1) && (level <= depth)) ? level : fallback;
    endfunction

    // Converts between a pin level and an internal active-high meaning.
    function automatic logic pin_map(input logic value, input bit act_low);
        return act_low ? ~value : value;
    endfunction

endpackage

// File: rtl/polfifo_ctrl.sv
module polfifo_ctrl
    import polfifo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic          rd_req,
    output fifo_op_e      op,
    output logic [CW-1:0] count
);

    logic at_full;
    logic at_empty;

    assign at_full  = (count == CW'(DEPTH));
    assign at_empty = (count == '0);

    // Push has precedence; a full queue blocks it and lets a pending pop through.
    always_comb begin
        if (wr_req && !at_full)
            op = OP_PUSH;
        else if (rd_req && !at_empty)
            op = OP_POP;
        else
            op = OP_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            case (op)
                OP_PUSH: count <= count + 1'b1;
                OP_POP:  count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    p_full_push_held_r6: assert property (@(posedge clk) disable iff (rst)
        (at_full && wr_req && !rd_req) |=> (count == $past(count)));

    p_both_push_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_req && rd_req && !at_full) |=> (count == $past(count) + 1'b1));

    p_both_full_pop_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_req && rd_req && at_full) |=> (count == $past(count) - 1'b1));

    p_empty_pop_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (at_empty && rd_req && !wr_req) |=> (count == '0));

endmodule

// File: rtl/polfifo_store.sv
module polfifo_store
    import polfifo_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    parameter int PW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  fifo_op_e         op,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst && op == OP_PUSH)
            mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            dout   <= '0;
        end else begin
            case (op)
                OP_PUSH: wr_ptr <= bump(wr_ptr);
                OP_POP: begin
                    dout   <= mem[rd_ptr];
                    rd_ptr <= bump(rd_ptr);
                end
                default: ;
            endcase
        end
    end

    p_dout_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (op != OP_POP) |=> $stable(dout));

endmodule

// File: rtl/polfifo_flags.sv
module polfifo_flags
    import polfifo_pkg::*;
#(
    parameter int DEPTH        = 8,
    parameter int CW           = 4,
    parameter int AFULL_LEVEL  = 0,
    parameter int AEMPTY_LEVEL = 0
) (
    input  logic [CW-1:0] count,
    output fifo_flags_t   flags
);

    // Out-of-range thresholds fall back to the full / empty decode points.
    localparam int AF_EFF = resolve_level(AFULL_LEVEL, DEPTH, DEPTH);
    localparam int AE_EFF = resolve_level(AEMPTY_LEVEL, DEPTH, 0);

    always_comb begin
        flags.full   = (count == CW'(DEPTH));
        flags.empty  = (count == '0);
        flags.afull  = (count >= CW'(AF_EFF));
        flags.aempty = (count <= CW'(AE_EFF));
    end

endmodule

// File: rtl/polfifo.sv
module polfifo
    import polfifo_pkg::*;
#(
    parameter int WIDTH          = 8,
    parameter int DEPTH          = 8,
    parameter int AFULL_LEVEL    = 0,
    parameter int AEMPTY_LEVEL   = 0,
    parameter bit PUSH_ACT_LOW   = 1'b0,
    parameter bit POP_ACT_LOW    = 1'b0,
    parameter bit FULL_ACT_LOW   = 1'b0,
    parameter bit EMPTY_ACT_LOW  = 1'b0,
    parameter bit AFULL_ACT_LOW  = 1'b0,
    parameter bit AEMPTY_ACT_LOW = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             almost_full_o,
    output logic             almost_empty_o
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic        wr_req;
    logic        rd_req;
    fifo_op_e    op;
    logic [CW-1:0] count;
    fifo_flags_t fl;

    assign wr_req = pin_map(push_i, PUSH_ACT_LOW);
    assign rd_req = pin_map(pop_i, POP_ACT_LOW);

    polfifo_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_req (wr_req),
        .rd_req (rd_req),
        .op     (op),
        .count  (count)
    );

    polfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PW(PW)) u_store (
        .clk  (clk),
        .rst  (rst),
        .op   (op),
        .din  (wdata_i),
        .dout (rdata_o)
    );

    polfifo_flags #(
        .DEPTH        (DEPTH),
        .CW           (CW),
        .AFULL_LEVEL  (AFULL_LEVEL),
        .AEMPTY_LEVEL (AEMPTY_LEVEL)
    ) u_flags (
        .count (count),
        .flags (fl)
    );

    assign full_o         = pin_map(fl.full,   FULL_ACT_LOW);
    assign empty_o        = pin_map(fl.empty,  EMPTY_ACT_LOW);
    assign almost_full_o  = pin_map(fl.afull,  AFULL_ACT_LOW);
    assign almost_empty_o = pin_map(fl.aempty, AEMPTY_ACT_LOW);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (fl.empty && fl.aempty && !fl.full && (rdata_o == '0)));

    p_af_covers_full_r9: assert property (@(posedge clk) disable iff (rst)
        fl.full |-> fl.afull);

    p_ae_covers_empty_r10: assert property (@(posedge clk) disable iff (rst)
        fl.empty |-> fl.aempty);

    p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        !(fl.full && fl.empty));

endmodule

// File: tb/polfifo_tb_top.sv
module polfifo_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int D = 4;
    localparam int NVEC = 19;

    // {push, pop, data}
    localparam logic [9:0] VEC [NVEC] = '{
        {2'b01, 8'h00},  // pop at empty
        {2'b11, 8'h11},  // both at empty
        {2'b10, 8'h22},
        {2'b11, 8'h33},  // both at mid level
        {2'b10, 8'h44},  // reaches full
        {2'b10, 8'h55},  // push at full
        {2'b11, 8'h66},  // both at full
        {2'b00, 8'h00},  // idle
        {2'b10, 8'h77},  // pointer wrap
        {2'b01, 8'h00},
        {2'b01, 8'h00},
        {2'b11, 8'h88},
        {2'b01, 8'h00},
        {2'b01, 8'h00},
        {2'b00, 8'h00},
        {2'b01, 8'h00},
        {2'b01, 8'h00},  // pop at empty after data
        {2'b11, 8'h99},
        {2'b01, 8'h00}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_push = 1'b0, a_pop = 1'b0;
    logic b_push = 1'b1, b_pop = 1'b1;
    logic c_push = 1'b0, c_pop = 1'b1;
    logic [7:0] wdata = '0;
    logic [7:0] a_rd, b_rd, c_rd;
    logic a_f, a_e, a_af, a_ae;
    logic b_f, b_e, b_af, b_ae;
    logic c_f, c_e, c_af, c_ae;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] mq[$];
    logic [7:0] mdout = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // All active-high, thresholds inside range.
    polfifo #(.WIDTH(8), .DEPTH(D), .AFULL_LEVEL(3), .AEMPTY_LEVEL(1)) dut_i (
        .clk(clk), .rst(rst), .push_i(a_push), .pop_i(a_pop), .wdata_i(wdata),
        .rdata_o(a_rd), .full_o(a_f), .empty_o(a_e),
        .almost_full_o(a_af), .almost_empty_o(a_ae));

    // All active-low, default thresholds of 0.
    polfifo #(.WIDTH(8), .DEPTH(D), .AFULL_LEVEL(0), .AEMPTY_LEVEL(0),
              .PUSH_ACT_LOW(1'b1), .POP_ACT_LOW(1'b1), .FULL_ACT_LOW(1'b1),
              .EMPTY_ACT_LOW(1'b1), .AFULL_ACT_LOW(1'b1), .AEMPTY_ACT_LOW(1'b1)) dut_lo (
        .clk(clk), .rst(rst), .push_i(b_push), .pop_i(b_pop), .wdata_i(wdata),
        .rdata_o(b_rd), .full_o(b_f), .empty_o(b_e),
        .almost_full_o(b_af), .almost_empty_o(b_ae));

    // Mixed polarity, thresholds above and below the valid range.
    polfifo #(.WIDTH(8), .DEPTH(D), .AFULL_LEVEL(9), .AEMPTY_LEVEL(-2),
              .PUSH_ACT_LOW(1'b0), .POP_ACT_LOW(1'b1), .FULL_ACT_LOW(1'b1),
              .EMPTY_ACT_LOW(1'b0), .AFULL_ACT_LOW(1'b1), .AEMPTY_ACT_LOW(1'b0)) dut_ov (
        .clk(clk), .rst(rst), .push_i(c_push), .pop_i(c_pop), .wdata_i(wdata),
        .rdata_o(c_rd), .full_o(c_f), .empty_o(c_e),
        .almost_full_o(c_af), .almost_empty_o(c_ae));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string ctx);
        int n = mq.size();
        chk({"R2 R3 rdata dut_i ", ctx}, int'(a_rd), int'(mdout));
        chk({"R11 rdata dut_lo ", ctx}, int'(b_rd), int'(mdout));
        chk({"R11 rdata dut_ov ", ctx}, int'(c_rd), int'(mdout));
        chk({"R8 full dut_i ", ctx}, int'(a_f), int'(n == D));
        chk({"R8 empty dut_i ", ctx}, int'(a_e), int'(n == 0));
        chk({"R9 afull dut_i ", ctx}, int'(a_af), int'(n >= 3));
        chk({"R10 aempty dut_i ", ctx}, int'(a_ae), int'(n <= 1));
        chk({"R11 full dut_lo ", ctx}, int'(b_f), int'(n != D));
        chk({"R11 empty dut_lo ", ctx}, int'(b_e), int'(n != 0));
        chk({"R9 afull fallback dut_lo ", ctx}, int'(b_af), int'(n != D));
        chk({"R10 aempty fallback dut_lo ", ctx}, int'(b_ae), int'(n != 0));
        chk({"R11 full dut_ov ", ctx}, int'(c_f), int'(n != D));
        chk({"R11 empty dut_ov ", ctx}, int'(c_e), int'(n == 0));
        chk({"R9 afull above range dut_ov ", ctx}, int'(c_af), int'(n != D));
        chk({"R10 aempty below range dut_ov ", ctx}, int'(c_ae), int'(n == 0));
    endtask

    task automatic drive(input bit w, input bit r, input logic [7:0] d);
        a_push = w;  a_pop = r;
        b_push = ~w; b_pop = ~r;
        c_push = w;  c_pop = ~r;
        wdata  = d;
    endtask

    task automatic step(input bit w, input bit r, input logic [7:0] d, input string ctx);
        @(negedge clk);
        drive(w, r, d);
        // Reference: push wins unless full; otherwise a pop if not empty.
        if (w && mq.size() < D) begin
            mq.push_back(d);
        end else if (r && mq.size() > 0) begin
            mdout = mq.pop_front();
        end
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk_all(ctx);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        drive(1'b0, 1'b0, 8'h00);
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        chk_all("R1 during reset");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk_all("R1 after release");

        for (int k = 0; k < NVEC; k++) begin
            step(VEC[k][9], VEC[k][8], VEC[k][7:0], $sformatf("R4 R5 R6 R7 vec %0d", k));
        end

        // Fill, then check that a blocked push did not overwrite stored words (R6).
        step(1'b1, 1'b0, 8'hA1, "fill");
        step(1'b1, 1'b0, 8'hA2, "fill");
        step(1'b1, 1'b0, 8'hA3, "fill");
        step(1'b1, 1'b0, 8'hA4, "fill");
        step(1'b1, 1'b0, 8'hEE, "R6 push at full");
        step(1'b1, 1'b1, 8'hEF, "R5 both at full");
        chk("R5 pop at full delivers oldest", int'(a_rd), 32'hA1);
        step(1'b0, 1'b1, 8'h00, "drain");
        step(1'b0, 1'b1, 8'h00, "drain");
        step(1'b0, 1'b1, 8'h00, "drain");
        chk("R6 last word not overwritten", int'(a_rd), 32'hA4);
        step(1'b0, 1'b0, 8'h00, "R3 idle hold");
        chk("R3 hold after drain", int'(a_rd), 32'hA4);

        // Reset with data in flight (R1).
        step(1'b1, 1'b0, 8'h5A, "preload");
        step(1'b1, 1'b0, 8'h5B, "preload");
        @(negedge clk);
        drive(1'b0, 1'b0, 8'h00);
        rst = 1'b1;
        mq.delete();
        mdout = '0;
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk_all("R1 mid-run reset");
        chk("R1 rdata cleared", int'(a_rd), 0);
        @(negedge clk);
        rst = 1'b0;
        step(1'b0, 1'b1, 8'h00, "R7 pop after reset");
        step(1'b1, 1'b0, 8'hC3, "push after reset");
        step(1'b0, 1'b1, 8'h00, "R2 pop after reset");
        chk("R2 word after reset", int'(a_rd), 32'hC3);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule